// File: doc/BRIEF.md
# Port Pin Change Monitor with Deferred Interrupt

This block watches a small group of general-purpose pins and reports when any of them changes. Each pin has its own direction, debounce enable and interrupt enable. A pin level first passes through a two-flop synchroniser. When debounce is enabled it also passes through a two-sample filter, which samples on a slow tick from a prescaler. Change is not measured against the previous clock. It is measured against a snapshot of the pin, which is taken each time the host reads that pin's register over the serial bus.

Each pin keeps a sticky change flag, and a summary flag combines them. A latching, active-low interrupt line is driven only by pins whose interrupt enable is set. The bus protocol engine is outside this block and supplies four things: a per-pin register read strobe, a summary register read strobe, a level that is high during a read transaction, and a one-cycle STOP pulse. While a read is in progress the interrupt line never goes active. A qualifying change during the read is held back and fires at STOP. It is dropped if the host reads that pin's register before STOP.

Top module: `pin_change_monitor`

## Requirements
- R1: After a synchronous reset, `irq_n_o` is 1, every `trans_flag_o` bit is 0 and `trans_any_o` is 0.
- R2: With debounce disabled for a pin, `port_val_o` shows the live pin level two clock edges after the pin changes, which is the delay of the two-flop synchroniser.
- R3: With debounce enabled for a pin, the stored level changes only when two consecutive tick samples agree. A pulse shorter than one tick period never reaches `port_val_o`, and `port_val_o` returns the stored level rather than the live pin.
- R4: A pin configured as an input (`cfg_dir_in_i` bit = 1) sets its `trans_flag_o` bit when its value differs from its snapshot, whatever its interrupt enable says. Only pins with `cfg_irq_en_i` bit = 1 can drive `irq_n_o` low.
- R5: A pulse on `port_rd_i[i]` copies pin i's value into its snapshot, and `trans_flag_o[i]` is 0 on the following cycle.
- R6: A pin configured as an output (`cfg_dir_in_i` bit = 0) never sets its flag and never drives `irq_n_o` low.
- R7: `trans_any_o` is 1 while any per-pin flag is set. It stays 1 until every flagged pin has been read. A pulse on `sum_rd_i` returns `irq_n_o` to 1.
- R8: While `rd_busy_i` is 1, `irq_n_o` does not fall. A qualifying change during the read drives `irq_n_o` low on the cycle after `stop_i`.
- R9: If the changed pin's register is read before `stop_i`, the held interrupt is dropped and `irq_n_o` stays 1.
- R10: `irq_n_o` is latching. Once low, it rises only after a `sum_rd_i` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_i | input | NPORT | Asynchronous pin levels |
| cfg_dir_in_i | input | NPORT | 1 = pin is an input |
| cfg_deb_en_i | input | NPORT | 1 = debounce enabled |
| cfg_irq_en_i | input | NPORT | 1 = pin may raise the interrupt |
| port_rd_i | input | NPORT | One-cycle read strobe per pin register |
| sum_rd_i | input | 1 | One-cycle read strobe of the summary register |
| rd_busy_i | input | 1 | High during a bus read transaction |
| stop_i | input | 1 | One-cycle STOP condition pulse |
| port_val_o | output | NPORT | Value a pin register read returns |
| trans_flag_o | output | NPORT | Sticky per-pin change flags |
| trans_any_o | output | 1 | Summary change flag |
| irq_n_o | output | 1 | Latching active-low interrupt |

## Verification
A stale snapshot shows up as a flag that sets again on the third edge after a read, with no pin movement. A wrong pending mask shows up as `irq_n_o` falling one cycle after a STOP that should have cancelled it, or not falling when it should. A debounce register that updates on one sample lets a pulse shorter than a tick reach `port_val_o` and the flags within two tick periods. A flag that is not gated by direction raises `trans_any_o` three edges after an output pin toggles.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    typedef struct packed {
        logic dir_in;
        logic deb_en;
        logic irq_en;
    } pin_cfg_t;

    typedef struct packed {
        logic value;   // effective (debounced or live) level
        logic flag;    // sticky change flag
        logic evt;     // flag is being newly set this cycle
    } pin_stat_t;

    function automatic pin_cfg_t make_cfg(logic dir_in, logic deb_en, logic irq_en);
        pin_cfg_t c;
        c.dir_in = dir_in;
        c.deb_en = deb_en;
        c.irq_en = irq_en;
        return c;
    endfunction

endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_i;
            stage2 <= stage1;
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/pcm_tick.sv
module pcm_tick #(
    parameter int TICK_DIV = 1550000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/pcm_pin_track.sv
module pcm_pin_track
    import pcm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      pin_sync_i,
    input  pin_cfg_t  cfg_i,
    input  logic      rd_i,
    output pin_stat_t stat_o
);
    logic sample_q;
    logic deb_q;
    logic snap_q;
    logic flag_q;
    logic eff;
    logic differs;

    // two-sample filter, updates only on tick cycles
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= 1'b0;
            deb_q    <= 1'b0;
        end else if (tick_i) begin
            sample_q <= pin_sync_i;
            if (pin_sync_i == sample_q) begin
                deb_q <= pin_sync_i;
            end
        end
    end

    assign eff     = cfg_i.deb_en ? deb_q : pin_sync_i;
    assign differs = (eff != snap_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (rd_i) begin
            snap_q <= eff;
            flag_q <= 1'b0;
        end else if (cfg_i.dir_in && differs) begin
            flag_q <= 1'b1;
        end
    end

    assign stat_o.value = eff;
    assign stat_o.flag  = flag_q;
    assign stat_o.evt   = cfg_i.dir_in & differs & ~flag_q & ~rd_i;
endmodule

// File: rtl/pcm_irq_ctl.sv
module pcm_irq_ctl #(
    parameter int NPORT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] evt_i,
    input  logic [NPORT-1:0] irq_en_i,
    input  logic [NPORT-1:0] port_rd_i,
    input  logic             sum_rd_i,
    input  logic             rd_busy_i,
    input  logic             stop_i,
    output logic             irq_o
);
    logic [NPORT-1:0] pend_q;
    logic [NPORT-1:0] pend_nxt;
    logic [NPORT-1:0] qual;
    logic             direct;
    logic             fire;

    always_comb begin
        qual     = evt_i & irq_en_i;
        pend_nxt = (pend_q & ~port_rd_i) | (rd_busy_i ? qual : '0);
        direct   = ~rd_busy_i & (|qual);
        fire     = stop_i & (|pend_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            irq_o  <= 1'b0;
        end else begin
            pend_q <= stop_i ? '0 : pend_nxt;
            if (direct || fire) begin
                irq_o <= 1'b1;
            end else if (sum_rd_i) begin
                irq_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pin_change_monitor.sv
module pin_change_monitor
    import pcm_pkg::*;
#(
    parameter int NPORT    = 4,
    parameter int TICK_DIV = 1550000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] pin_i,
    input  logic [NPORT-1:0] cfg_dir_in_i,
    input  logic [NPORT-1:0] cfg_deb_en_i,
    input  logic [NPORT-1:0] cfg_irq_en_i,
    input  logic [NPORT-1:0] port_rd_i,
    input  logic             sum_rd_i,
    input  logic             rd_busy_i,
    input  logic             stop_i,
    output logic [NPORT-1:0] port_val_o,
    output logic [NPORT-1:0] trans_flag_o,
    output logic             trans_any_o,
    output logic             irq_n_o
);
    logic [NPORT-1:0] pin_sync;
    logic [NPORT-1:0] evt;
    logic             tick;
    logic             irq;

    pcm_sync #(.WIDTH(NPORT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_i),
        .q_o (pin_sync)
    );

    pcm_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_pin
        pin_stat_t st;
        pcm_pin_track u_track (
            .clk        (clk),
            .rst        (rst),
            .tick_i     (tick),
            .pin_sync_i (pin_sync[i]),
            .cfg_i      (make_cfg(cfg_dir_in_i[i], cfg_deb_en_i[i], cfg_irq_en_i[i])),
            .rd_i       (port_rd_i[i]),
            .stat_o     (st)
        );
        assign port_val_o[i]   = st.value;
        assign trans_flag_o[i] = st.flag;
        assign evt[i]          = st.evt;
    end

    pcm_irq_ctl #(.NPORT(NPORT)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .irq_en_i  (cfg_irq_en_i),
        .port_rd_i (port_rd_i),
        .sum_rd_i  (sum_rd_i),
        .rd_busy_i (rd_busy_i),
        .stop_i    (stop_i),
        .irq_o     (irq)
    );

    assign trans_any_o = |trans_flag_o;
    assign irq_n_o     = ~irq;
endmodule

// File: rtl/pin_change_monitor_chk.sv
module pin_change_monitor_chk #(
    parameter int NPORT = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NPORT-1:0] cfg_dir_in_i,
    input logic [NPORT-1:0] port_rd_i,
    input logic             sum_rd_i,
    input logic             rd_busy_i,
    input logic             stop_i,
    input logic [NPORT-1:0] trans_flag_o,
    input logic             irq_n_o
);
    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        // R6: only an input pin can raise its flag
        a_r6_output_no_flag: assert property (@(posedge clk) disable iff (rst)
            $rose(trans_flag_o[i]) |-> $past(cfg_dir_in_i[i]));
        // R5: a register read leaves the flag clear on the next cycle
        a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
            port_rd_i[i] |=> !trans_flag_o[i]);
    end

    // R8: no falling edge of the interrupt inside a read
    a_r8_hold_in_read: assert property (@(posedge clk) disable iff (rst)
        (rd_busy_i && !stop_i && irq_n_o) |=> irq_n_o);

    // R10: interrupt leaves the active state only after a summary read
    a_r10_latching: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n_o) |-> $past(sum_rd_i));
endmodule

bind pin_change_monitor pin_change_monitor_chk #(.NPORT(NPORT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_dir_in_i (cfg_dir_in_i),
    .port_rd_i    (port_rd_i),
    .sum_rd_i     (sum_rd_i),
    .rd_busy_i    (rd_busy_i),
    .stop_i       (stop_i),
    .trans_flag_o (trans_flag_o),
    .irq_n_o      (irq_n_o)
);

// File: tb/pin_change_monitor_bench.sv
module pin_change_monitor_bench;
    localparam int NPORT    = 4;
    localparam int TICK_DIV = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NPORT-1:0] pin_i = '0;
    logic [NPORT-1:0] cfg_dir_in_i = '0;
    logic [NPORT-1:0] cfg_deb_en_i = '0;
    logic [NPORT-1:0] cfg_irq_en_i = '0;
    logic [NPORT-1:0] port_rd_i = '0;
    logic             sum_rd_i = 1'b0;
    logic             rd_busy_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [NPORT-1:0] port_val_o;
    logic [NPORT-1:0] trans_flag_o;
    logic             trans_any_o;
    logic             irq_n_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pin_change_monitor #(.NPORT(NPORT), .TICK_DIV(TICK_DIV)) u_pin_change_monitor (
        .clk          (clk),
        .rst          (rst),
        .pin_i        (pin_i),
        .cfg_dir_in_i (cfg_dir_in_i),
        .cfg_deb_en_i (cfg_deb_en_i),
        .cfg_irq_en_i (cfg_irq_en_i),
        .port_rd_i    (port_rd_i),
        .sum_rd_i     (sum_rd_i),
        .rd_busy_i    (rd_busy_i),
        .stop_i       (stop_i),
        .port_val_o   (port_val_o),
        .trans_flag_o (trans_flag_o),
        .trans_any_o  (trans_any_o),
        .irq_n_o      (irq_n_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_port(input int p);
        port_rd_i[p] = 1'b1;
        wait_n(1);
        port_rd_i = '0;
        wait_n(2);
    endtask

    task automatic read_sum();
        sum_rd_i = 1'b1;
        wait_n(1);
        sum_rd_i = 1'b0;
        wait_n(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state
        chk("R1 irq_n", {31'd0, irq_n_o}, 32'd1);
        chk("R1 flags", {28'd0, trans_flag_o}, 32'd0);
        chk("R1 any", {31'd0, trans_any_o}, 32'd0);

        // sweep: every pin, every direction/enable pair, both edges
        for (int p = 0; p < NPORT; p++) begin
            for (int m = 0; m < 8; m++) begin
                logic dir;
                logic ie;
                logic exp_irq;
                dir = m[0];
                ie  = m[1];
                exp_irq = dir & ie;
                cfg_dir_in_i = '0;
                cfg_irq_en_i = '0;
                cfg_dir_in_i[p] = dir;
                cfg_irq_en_i[p] = ie;
                pin_i[p] = ~pin_i[p];
                wait_n(2);
                // R2 live value after two edges
                chk("R2 live value", {31'd0, port_val_o[p]}, {31'd0, pin_i[p]});
                wait_n(2);
                chk(dir ? "R4 flag set" : "R6 output no flag", {31'd0, trans_flag_o[p]}, {31'd0, dir});
                chk("R7 any", {31'd0, trans_any_o}, {31'd0, dir});
                chk(dir ? "R4 irq gated by enable" : "R6 output no irq", {31'd0, irq_n_o}, {31'd0, ~exp_irq});
                wait_n(3);
                chk("R10 irq latched", {31'd0, irq_n_o}, {31'd0, ~exp_irq});
                read_port(p);
                chk("R5 read clears flag", {31'd0, trans_flag_o[p]}, 32'd0);
                read_sum();
                chk("R7 summary read clears irq", {31'd0, irq_n_o}, 32'd1);
            end
        end

        // R7: summary stays until every flagged pin is read
        cfg_dir_in_i = '1;
        cfg_irq_en_i = '0;
        pin_i[0] = ~pin_i[0];
        pin_i[2] = ~pin_i[2];
        wait_n(4);
        chk("R7 two flags", {28'd0, trans_flag_o}, 32'h5);
        read_port(0);
        chk("R7 any held after partial read", {31'd0, trans_any_o}, 32'd1);
        read_port(2);
        chk("R7 any clear after all read", {31'd0, trans_any_o}, 32'd0);

        // R8: deferred to STOP
        cfg_irq_en_i = '1;
        rd_busy_i = 1'b1;
        pin_i[1] = ~pin_i[1];
        wait_n(5);
        chk("R8 flag during read", {31'd0, trans_flag_o[1]}, 32'd1);
        chk("R8 irq held during read", {31'd0, irq_n_o}, 32'd1);
        stop_i = 1'b1;
        wait_n(1);
        stop_i = 1'b0;
        rd_busy_i = 1'b0;
        chk("R8 irq at stop", {31'd0, irq_n_o}, 32'd0);
        read_port(1);
        read_sum();
        chk("R8 cleared", {31'd0, irq_n_o}, 32'd1);

        // R9: read before STOP cancels
        rd_busy_i = 1'b1;
        pin_i[3] = ~pin_i[3];
        wait_n(5);
        read_port(3);
        stop_i = 1'b1;
        wait_n(1);
        stop_i = 1'b0;
        rd_busy_i = 1'b0;
        wait_n(2);
        chk("R9 cancelled irq", {31'd0, irq_n_o}, 32'd1);
        chk("R9 flag clear", {31'd0, trans_flag_o[3]}, 32'd0);

        // R3: debounce
        cfg_deb_en_i[0] = 1'b1;
        wait_n(5 * TICK_DIV);
        read_port(0);
        read_sum();
        begin
            logic old;
            old = pin_i[0];
            pin_i[0] = ~old;
            wait_n(3);
            pin_i[0] = old;
            wait_n(5 * TICK_DIV);
            chk("R3 glitch value", {31'd0, port_val_o[0]}, {31'd0, old});
            chk("R3 glitch no flag", {31'd0, trans_flag_o[0]}, 32'd0);
            chk("R3 glitch no irq", {31'd0, irq_n_o}, 32'd1);
            pin_i[0] = ~old;
            wait_n(4);
            chk("R3 returns stored level", {31'd0, port_val_o[0]}, {31'd0, old});
            wait_n(5 * TICK_DIV);
            chk("R3 stable change accepted", {31'd0, port_val_o[0]}, {31'd0, ~old});
            chk("R3 flag on debounced", {31'd0, trans_flag_o[0]}, 32'd1);
            chk("R3 irq on debounced", {31'd0, irq_n_o}, 32'd0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule